// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a free-running 8-bit up-counter for periodic interrupts. It is paced by a built-in prescaler. The prescaler is a binary counter that advances on every system clock while it is enabled. A 3-bit select picks one of its eight upper bits, PS4 through PS11, as the count clock. The counter advances once for each rising edge of the selected bit. When the counter rolls over from 0xFF to 0x00, two things happen. An interrupt request flag is latched, and it stays set until acknowledged. A single-cycle pulse also goes to a downstream watchdog as that watchdog's clock source.

Software reaches the block through one bus address, 0xD3. A write at that address loads an 8-bit control byte. The control byte holds the tap select, a self-clearing counter-clear bit, a prescaler enable and a watchdog enable. The last two are passed out as pins. A read at that address returns the live counter value.

Top module: `ivtimer`

## Requirements
- R1: After a synchronous active-low reset, the count reads 0x00. After the same reset, `irq_flag`, `wdt_tick`, `wdt_en` and `pck_en` are all 0.
- R2: A bus write (`bus_wr`=1 with `bus_addr`=0xD3) loads the control byte on that clock edge. Control bit 6 then drives `wdt_en` and bit 5 drives `pck_en`. A write at any other address changes nothing.
- R3: With `bus_addr`=0xD3, `bus_rdata` shows the current count. With any other address, it reads 0x00.
- R4: Control bits [2:0] hold a select value s, which picks prescaler bit 4+s (0 picks PS4, 7 picks PS11). The counter rises by one on each rising edge of that bit, which is one step every 2^(s+5) clocks.
- R5: Writing control bit 3 as 1 sets the clear bit. The count reads 0x00 after the following clock edge.
- R6: The clear bit returns to 0 by itself one cycle after it is set, and counting then resumes. A clear wins over a count step that falls in the same cycle.
- R7: While control bit 5 is 0, the prescaler holds and the count does not change.
- R8: On the edge where the count wraps from 0xFF to 0x00, `irq_flag` becomes 1. It stays 1 until `irq_ack` is high at a clock edge. A new wrap in the same cycle as an acknowledge keeps the flag set.
- R9: `wdt_tick` is high for exactly one cycle, starting on the same edge as each wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data (control byte) |
| bus_rdata | output | 8 | Read data: live count at 0xD3, else 0 |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq_flag | output | 1 | Interrupt request flag |
| wdt_tick | output | 1 | One-cycle wrap pulse for the watchdog |
| wdt_en | output | 1 | Watchdog enable (control bit 6) |
| pck_en | output | 1 | Prescaler enable (control bit 5) |

## Verification
Some rules are local to a single cycle, and the assertions check these on every cycle. A set clear bit zeroes the counter on the next edge and then drops itself. The count holds on cycles with no tick. The prescaler freezes while disabled. A tick never lasts two cycles. A wrap sets the flag and produces a pulse that lasts one cycle only. Other behaviour needs a stimulus and a wait. The step period for each select value, the full rollover to 0x00 with its flag and pulse, acknowledge, the shared-address read/write split and the enable pins are shown only by the bench's scenarios, which read the count back through the bus.

// File: rtl/ivt_pkg.sv
// Package: shared control-byte layout for the interval timer.
// Assumes an 8-bit control byte; bit positions match the bus contract.
package ivt_pkg;
    typedef struct packed {
        logic       rsv7;    // unused
        logic       wdt_on;  // bit 6: watchdog enable
        logic       pck_on;  // bit 5: prescaler enable
        logic       rsv4;    // unused
        logic       clr;     // bit 3: self-clearing counter clear
        logic [2:0] sel;     // bits 2:0: prescaler tap select
    } ctrl_t;
endpackage

// File: rtl/ivt_prescaler.sv
// Module: free-running binary prescaler.
// Advances by one each clock while en is high and holds otherwise.
// Bit n of the output is the divided tap PSn.
module ivt_prescaler #(
    parameter int PS_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    output logic [PS_W-1:0] ps
);
    // Purpose: advance the divider chain when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)  ps <= '0;
        else if (en) ps <= ps + 1'b1;
    end

    AST_PS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ps)); // R7
endmodule

// File: rtl/ivt_tapsel.sv
// Module: selects one prescaler tap and emits a one-cycle tick on its rising edge.
// Assumes PS_W >= TAP_LO + 2**SEL_W.
// A change of select may give one early tick, which is accepted.
module ivt_tapsel #(
    parameter int PS_W   = 12,
    parameter int TAP_LO = 4,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PS_W-1:0]  ps,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NTAPS = 2 ** SEL_W;

    logic [NTAPS-1:0] taps;
    logic             tap_now;
    logic             tap_q;

    genvar gi;
    generate
        for (gi = 0; gi < NTAPS; gi++) begin : g_tap
            assign taps[gi] = ps[TAP_LO + gi];
        end
    endgenerate

    // Purpose: pick the selected tap.
    always_comb tap_now = taps[sel];

    // Purpose: remember the previous tap level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= 1'b0;
        else        tap_q <= tap_now;
    end

    // Purpose: tick on the rising edge of the chosen tap.
    always_comb tick = tap_now & ~tap_q;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
endmodule

// File: rtl/ivt_counter.sv
// Module: 8-bit interval counter with wrap flag and watchdog pulse.
// Clear has priority over a tick. A wrap sets the flag with priority over acknowledge.
module ivt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             ack,
    output logic [CNT_W-1:0] cnt,
    output logic             irq_flag,
    output logic             wrap_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wrap_now;

    // Purpose: detect a step that rolls the counter over.
    always_comb wrap_now = tick && !clr && (cnt == CNT_MAX);

    // Purpose: count up on ticks, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // Purpose: one-cycle watchdog pulse aligned with the wrap edge.
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_pulse <= 1'b0;
        else        wrap_pulse <= wrap_now;
    end

    // Purpose: sticky interrupt flag, set by wrap, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_flag <= 1'b0;
        else if (wrap_now) irq_flag <= 1'b1;
        else if (ack)      irq_flag <= 1'b0;
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt)); // R4
    AST_WRAP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt == CNT_MAX) |=> (irq_flag && cnt == '0)); // R8
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse); // R9
endmodule

// File: rtl/ivtimer.sv
// Module: prescaled interval timer top.
// A write at REG_ADDR loads the control byte. A read there returns the count.
// The clear bit drops itself one cycle after it is set.
module ivtimer #(
    parameter int           ADDR_W   = 8,
    parameter int           DATA_W   = 8,
    parameter int           PS_W     = 12,
    parameter int           TAP_LO   = 4,
    parameter int           SEL_W    = 3,
    parameter logic [7:0]   REG_ADDR = 8'hD3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_ack,
    output logic              irq_flag,
    output logic              wdt_tick,
    output logic              wdt_en,
    output logic              pck_en
);
    import ivt_pkg::*;

    localparam int CNT_W = DATA_W;

    ctrl_t             ctrl;
    logic              hit;
    logic              wr_hit;
    logic [PS_W-1:0]   ps;
    logic              tick;
    logic [CNT_W-1:0]  cnt;

    // Purpose: decode the shared address.
    always_comb begin
        hit    = (bus_addr == REG_ADDR[ADDR_W-1:0]);
        wr_hit = hit && bus_wr;
    end

    // Purpose: load control on write; the clear bit drops itself afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl <= '0;
        else if (wr_hit)   ctrl <= ctrl_t'(bus_wdata);
        else if (ctrl.clr) ctrl.clr <= 1'b0;
    end

    // Purpose: read path returns the live count at the shared address.
    always_comb begin
        bus_rdata = hit ? cnt : '0;
        wdt_en    = ctrl.wdt_on;
        pck_en    = ctrl.pck_on;
    end

    ivt_prescaler #(.PS_W(PS_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .en(ctrl.pck_on), .ps(ps)
    );

    ivt_tapsel #(.PS_W(PS_W), .TAP_LO(TAP_LO), .SEL_W(SEL_W)) u_tap (
        .clk(clk), .rst_n(rst_n), .ps(ps), .sel(ctrl.sel), .tick(tick)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(ctrl.clr), .ack(irq_ack),
        .cnt(cnt), .irq_flag(irq_flag), .wrap_pulse(wdt_tick)
    );

    AST_CLR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.clr && !wr_hit) |=> !ctrl.clr); // R6
    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (pck_en == $past(bus_wdata[5]) && wdt_en == $past(bus_wdata[6]))); // R2
endmodule

// File: tb/ivtimer_test.sv
// Bench: directed scenarios for the interval timer, one task per scenario.
module ivtimer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'hD3;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_flag, wdt_tick, wdt_en, pck_en;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    ivtimer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .irq_flag(irq_flag), .wdt_tick(wdt_tick), .wdt_en(wdt_en), .pck_en(pck_en)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] addr, input logic [7:0] d);
        @(negedge clk);
        bus_addr = addr; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'hD3;
    endtask

    // waits at negedges until the read value changes; returns cycles waited
    task automatic wait_change(input int limit, output int n);
        logic [7:0] prev;
        prev = bus_rdata;
        n = 0;
        while (bus_rdata == prev && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(bus_rdata == 8'h00, "R1 count", bus_rdata, 0);
        check(!irq_flag && !wdt_tick, "R1 irq/tick", {irq_flag, wdt_tick}, 0);
        check(!wdt_en && !pck_en, "R1 enables", {wdt_en, pck_en}, 0);
    endtask

    task automatic t_write_pins;
        wr_ctrl(8'hD3, 8'h60);
        check(wdt_en && pck_en, "R2 pins set", {wdt_en, pck_en}, 3);
        wr_ctrl(8'h10, 8'h00);
        check(wdt_en && pck_en, "R2 other addr ignored", {wdt_en, pck_en}, 3);
        wr_ctrl(8'hD3, 8'h20);
        check(!wdt_en && pck_en, "R2 wdt off", {wdt_en, pck_en}, 1);
    endtask

    task automatic t_period(input int s);
        int n;
        wr_ctrl(8'hD3, 8'h20 | s[7:0]);
        wait_change(20000, n);
        wait_change(20000, n);
        check(n == (1 << (s + 5)), $sformatf("R4 period sel=%0d", s), n, 1 << (s + 5));
    endtask

    task automatic t_read_addr;
        int n;
        wr_ctrl(8'hD3, 8'h20);
        wait_change(100, n);
        check(bus_rdata != 8'h00, "R3 live count", bus_rdata, 1);
        @(negedge clk);
        bus_addr = 8'h42;
        #1;
        check(bus_rdata == 8'h00, "R3 other addr reads 0", bus_rdata, 0);
        bus_addr = 8'hD3;
    endtask

    task automatic t_clear;
        int n;
        wr_ctrl(8'hD3, 8'h20);
        repeat (100) @(negedge clk);
        check(bus_rdata != 8'h00, "R5 precondition count", bus_rdata, 1);
        wr_ctrl(8'hD3, 8'h28);
        @(negedge clk);
        check(bus_rdata == 8'h00, "R5 cleared", bus_rdata, 0);
        repeat (400) @(negedge clk);
        check(bus_rdata >= 8'd10, "R6 counting resumes", bus_rdata, 12);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        wr_ctrl(8'hD3, 8'h20);
        repeat (100) @(negedge clk);
        wr_ctrl(8'hD3, 8'h00);
        v = bus_rdata;
        repeat (3000) @(negedge clk);
        check(bus_rdata == v, "R7 held while prescaler off", bus_rdata, v);
    endtask

    task automatic t_wrap;
        int n;
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check(!irq_flag, "R8 flag clear before wrap", irq_flag, 0);
        wr_ctrl(8'hD3, 8'h28);
        n = 0;
        while (bus_rdata != 8'hFF && n < 20000) begin @(negedge clk); n++; end
        check(!irq_flag && !wdt_tick, "R8 no flag before wrap", {irq_flag, wdt_tick}, 0);
        wait_change(100, n);
        check(bus_rdata == 8'h00, "R8 wrapped to 0", bus_rdata, 0);
        check(irq_flag, "R8 flag on wrap edge", irq_flag, 1);
        check(wdt_tick, "R9 pulse on wrap edge", wdt_tick, 1);
        @(negedge clk);
        check(!wdt_tick, "R9 pulse one cycle", wdt_tick, 0);
        repeat (50) @(negedge clk);
        check(irq_flag, "R8 flag sticky", irq_flag, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check(!irq_flag, "R8 ack clears", irq_flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_pins();
        t_read_addr();
        t_period(0);
        t_period(2);
        t_period(7);
        t_clear();
        t_hold();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule